// File: doc/BRIEF.md
# Dataflow-Synchronized Thread Scheduler

This block decides which thread the fetch stage of a single-issue, in-order, multithreaded core works on next. Ready threads wait in a FIFO of thread identifiers. Each one comes with the program counter it must resume at. Every architectural register carries a small state machine with three states: FULL, PENDING and WAITING. A long-latency asynchronous operation turns its destination PENDING, and its thread keeps issuing. A thread is parked only when one of its instructions reads a register that is still PENDING. The register then turns WAITING and remembers the parked thread. When the asynchronous result is written back, the thread goes back into the ready queue.

Instructions that may block carry a switch hint. A hinted instruction that does not block sends its thread to the tail of the queue, with the following PC. The fetch stage therefore moves to another thread without losing a cycle. A parked thread resumes at the instruction that blocked it.

After reset every thread is in the queue in ascending order, all with PC 0, and every register is FULL.

Top module: `dfs_sched`

## Requirements
- R1: After reset the queue offers threads 0, 1, … NTHR-1 in that order, each with PC 0, and every register is FULL.
- R2: `fq_vld_o` is high exactly when the queue is non-empty. `fq_tid_o`/`fq_pc_o` show the head entry. A cycle with `fq_req_i` and `fq_vld_o` both high removes the head.
- R3: An issued instruction with `is_async_i`, if it is not blocked, makes register `is_dst_i` PENDING. A later read of that register blocks.
- R4: An instruction whose valid sources are all FULL raises neither `is_susp_o` nor `is_retry_o`.
- R5: A read of a PENDING register raises `is_susp_o` in the same cycle. The register becomes WAITING and stores the thread and the instruction's PC. The thread is not queued.
- R6: A writeback to a WAITING register makes it FULL and appends the stored thread to the queue. Fetch later delivers that thread with the PC of the instruction that blocked.
- R7: A writeback to a PENDING register makes it FULL and queues nothing.
- R8: When a writeback and a read of the same register fall in one cycle, the read sees it as FULL and does not block.
- R9: A hinted instruction that is not blocked appends its thread to the queue with PC `is_pc_i`+1.
- R10: A read of a WAITING register raises `is_retry_o` and appends the thread with its unchanged PC. The stored waiter is kept and is still woken by the writeback.
- R11: If a wake-up and a requeue happen in the same cycle, the woken thread enters the queue first.
- R12: The queue holds all NTHR threads, so it never refuses a push: NTHR threads parked and then woken all come back in wake-up order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_req_i | input | 1 | Fetch takes the head thread |
| fq_vld_o | output | 1 | A ready thread is offered |
| fq_tid_o | output | 4 | Offered thread id |
| fq_pc_o | output | 16 | Resume PC of the offered thread |
| is_vld_i | input | 1 | An instruction issues this cycle |
| is_tid_i | input | 4 | Issuing thread |
| is_pc_i | input | 16 | PC of the issuing instruction |
| is_sa_vld_i | input | 1 | Source A is read |
| is_sa_i | input | 6 | Source A register |
| is_sb_vld_i | input | 1 | Source B is read |
| is_sb_i | input | 6 | Source B register |
| is_async_i | input | 1 | Instruction starts an asynchronous operation |
| is_dst_i | input | 6 | Destination register of that operation |
| is_hint_i | input | 1 | Switch hint (may-suspend flag) |
| is_susp_o | output | 1 | Thread parked on a PENDING source |
| is_retry_o | output | 1 | Thread requeued: source already has a waiter |
| wb_vld_i | input | 1 | Asynchronous completion writes back |
| wb_reg_i | input | 6 | Register being completed |

## Verification
Two events can land in the same cycle. One is the completion of a register, which may wake a waiter. The other is an issue that reads that register or requeues a thread. The directed cases line these up on purpose: a read and a writeback of one register together must not block, and a wake-up alongside a hinted requeue must leave the woken thread ahead in the queue. The constrained-random phase uses only eight registers and issues often, so such collisions keep occurring. Every cycle is judged against a bench model of the register states and the queue.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    typedef enum logic [1:0] {
        RS_FULL = 2'd0,
        RS_PEND = 2'd1,
        RS_WAIT = 2'd2
    } rstate_e;
endpackage

// File: rtl/dfs_readyq.sv
module dfs_readyq #(
    parameter int NTHR = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push0_i,
    input  logic [$clog2(NTHR)-1:0]       tid0_i,
    input  logic                          push1_i,
    input  logic [$clog2(NTHR)-1:0]       tid1_i,
    input  logic                          pop_i,
    output logic                          vld_o,
    output logic [$clog2(NTHR)-1:0]       head_o,
    output logic [$clog2(NTHR+1)-1:0]     cnt_o
);
    localparam int TW = $clog2(NTHR);
    localparam int CW = $clog2(NTHR+1);

    logic [TW-1:0] mem_q [NTHR];
    logic [TW-1:0] hd_q;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] tail0, tail1;

    // pointers wrap by truncation (NTHR is a power of two)
    assign tail0  = hd_q + TW'(cnt_q);
    assign tail1  = tail0 + TW'(push0_i);
    assign vld_o  = (cnt_q != '0);
    assign head_o = mem_q[hd_q];
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTHR; i++) mem_q[i] <= TW'(i);
            hd_q  <= '0;
            cnt_q <= CW'(NTHR);
        end else begin
            hd_q  <= hd_q + TW'(pop_i);
            cnt_q <= cnt_q + CW'(push0_i) + CW'(push1_i) - CW'(pop_i);
            if (push0_i) mem_q[tail0] <= tid0_i;
            if (push1_i) mem_q[tail1] <= tid1_i;
        end
    end
endmodule

// File: rtl/dfs_regstate.sv
module dfs_regstate
    import dfs_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NTHR = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NREG)-1:0]   ra_i,
    input  logic [$clog2(NREG)-1:0]   rb_i,
    output rstate_e                   sa_o,
    output rstate_e                   sb_o,
    input  logic                      wb_vld_i,
    input  logic [$clog2(NREG)-1:0]   wb_reg_i,
    output logic                      wake_o,
    output logic [$clog2(NTHR)-1:0]   wake_tid_o,
    input  logic                      mark_vld_i,
    input  logic [$clog2(NREG)-1:0]   mark_reg_i,
    input  logic                      park_vld_i,
    input  logic [$clog2(NREG)-1:0]   park_reg_i,
    input  logic [$clog2(NTHR)-1:0]   park_tid_i
);
    localparam int RW = $clog2(NREG);
    localparam int TW = $clog2(NTHR);

    rstate_e       st_q [NREG];
    rstate_e       st_d [NREG];
    logic [TW-1:0] wt_q [NREG];

    assign sa_o       = st_q[ra_i];
    assign sb_o       = st_q[rb_i];
    assign wake_o     = wb_vld_i && (st_q[wb_reg_i] == RS_WAIT);
    assign wake_tid_o = wt_q[wb_reg_i];

    // next-state logic of every register's FULL/PENDING/WAITING machine
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            logic hit_wb, hit_mk, hit_pk;
            hit_wb  = wb_vld_i   && (wb_reg_i   == RW'(r));
            hit_mk  = mark_vld_i && (mark_reg_i == RW'(r));
            hit_pk  = park_vld_i && (park_reg_i == RW'(r));
            st_d[r] = st_q[r];
            unique case (st_q[r])
                RS_FULL: if (hit_mk) st_d[r] = RS_PEND;
                RS_PEND: begin
                    if (hit_wb)      st_d[r] = hit_mk ? RS_PEND : RS_FULL;
                    else if (hit_pk) st_d[r] = RS_WAIT;
                end
                RS_WAIT: if (hit_wb) st_d[r] = hit_mk ? RS_PEND : RS_FULL;
                default: st_d[r] = RS_FULL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                st_q[r] <= RS_FULL;
                wt_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) st_q[r] <= st_d[r];
            if (park_vld_i) wt_q[park_reg_i] <= park_tid_i;
        end
    end
endmodule

// File: rtl/dfs_sched.sv
module dfs_sched
    import dfs_pkg::*;
#(
    parameter int NTHR = 16,
    parameter int NREG = 64,
    parameter int PCW  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fq_req_i,
    output logic                       fq_vld_o,
    output logic [$clog2(NTHR)-1:0]    fq_tid_o,
    output logic [PCW-1:0]             fq_pc_o,
    input  logic                       is_vld_i,
    input  logic [$clog2(NTHR)-1:0]    is_tid_i,
    input  logic [PCW-1:0]             is_pc_i,
    input  logic                       is_sa_vld_i,
    input  logic [$clog2(NREG)-1:0]    is_sa_i,
    input  logic                       is_sb_vld_i,
    input  logic [$clog2(NREG)-1:0]    is_sb_i,
    input  logic                       is_async_i,
    input  logic [$clog2(NREG)-1:0]    is_dst_i,
    input  logic                       is_hint_i,
    output logic                       is_susp_o,
    output logic                       is_retry_o,
    input  logic                       wb_vld_i,
    input  logic [$clog2(NREG)-1:0]    wb_reg_i
);
    localparam int TW = $clog2(NTHR);
    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(NTHR+1);

    rstate_e        st_a, st_b, blk_st;
    logic           blk_a, blk_b, blocked;
    logic [RW-1:0]  blk_reg;
    logic           mark, requeue, wake;
    logic [TW-1:0]  wake_tid, head;
    logic [PCW-1:0] rq_pc;
    logic [PCW-1:0] pc_q [NTHR];
    logic [CW-1:0]  q_cnt;
    logic           pop;

    dfs_regstate #(.NREG(NREG), .NTHR(NTHR)) u_rs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ra_i       (is_sa_i),
        .rb_i       (is_sb_i),
        .sa_o       (st_a),
        .sb_o       (st_b),
        .wb_vld_i   (wb_vld_i),
        .wb_reg_i   (wb_reg_i),
        .wake_o     (wake),
        .wake_tid_o (wake_tid),
        .mark_vld_i (mark),
        .mark_reg_i (is_dst_i),
        .park_vld_i (is_susp_o),
        .park_reg_i (blk_reg),
        .park_tid_i (is_tid_i)
    );

    // issue decode: a same-cycle writeback bypasses the source check
    always_comb begin
        blk_a      = is_sa_vld_i && (st_a != RS_FULL) && !(wb_vld_i && wb_reg_i == is_sa_i);
        blk_b      = is_sb_vld_i && (st_b != RS_FULL) && !(wb_vld_i && wb_reg_i == is_sb_i);
        blocked    = is_vld_i && (blk_a || blk_b);
        blk_st     = blk_a ? st_a : st_b;
        blk_reg    = blk_a ? is_sa_i : is_sb_i;
        is_susp_o  = blocked && (blk_st == RS_PEND);
        is_retry_o = blocked && (blk_st == RS_WAIT);
        mark       = is_vld_i && !blocked && is_async_i;
        requeue    = is_retry_o || (is_vld_i && !blocked && is_hint_i);
        rq_pc      = is_retry_o ? is_pc_i : is_pc_i + PCW'(1);
    end

    assign pop = fq_req_i && fq_vld_o;

    dfs_readyq #(.NTHR(NTHR)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push0_i (wake),
        .tid0_i  (wake_tid),
        .push1_i (requeue),
        .tid1_i  (is_tid_i),
        .pop_i   (pop),
        .vld_o   (fq_vld_o),
        .head_o  (head),
        .cnt_o   (q_cnt)
    );

    assign fq_tid_o = head;
    assign fq_pc_o  = pc_q[head];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTHR; t++) pc_q[t] <= '0;
        end else if (is_susp_o) begin
            pc_q[is_tid_i] <= is_pc_i;
        end else if (requeue) begin
            pc_q[is_tid_i] <= rq_pc;
        end
    end
endmodule

// File: rtl/dfs_sched_chk.sv
module dfs_sched_chk #(
    parameter int NTHR = 16,
    parameter int NREG = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fq_req_i,
    input logic                      fq_vld_o,
    input logic                      is_vld_i,
    input logic                      is_hint_i,
    input logic                      is_sa_vld_i,
    input logic [$clog2(NREG)-1:0]   is_sa_i,
    input logic                      is_sb_vld_i,
    input logic                      wb_vld_i,
    input logic [$clog2(NREG)-1:0]   wb_reg_i,
    input logic                      is_susp_o,
    input logic                      is_retry_o,
    input logic [$clog2(NTHR+1)-1:0] q_cnt
);
    localparam int CW = $clog2(NTHR+1);

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(NTHR));

    a_r4_idle_no_block: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vld_i |-> (!is_susp_o && !is_retry_o));

    a_r5_susp_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_susp_o && is_retry_o));

    a_r8_wb_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (is_vld_i && wb_vld_i && is_sa_vld_i && !is_sb_vld_i && wb_reg_i == is_sa_i)
        |-> (!is_susp_o && !is_retry_o));

    a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fq_req_i && fq_vld_o && !is_vld_i && !wb_vld_i) |=> (q_cnt == $past(q_cnt) - CW'(1)));

    a_r9_hint_push: assert property (@(posedge clk) disable iff (!rst_n)
        (is_vld_i && is_hint_i && !is_susp_o && !is_retry_o && !wb_vld_i && !fq_req_i)
        |=> (q_cnt == $past(q_cnt) + CW'(1)));
endmodule

bind dfs_sched dfs_sched_chk #(.NTHR(NTHR), .NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fq_req_i    (fq_req_i),
    .fq_vld_o    (fq_vld_o),
    .is_vld_i    (is_vld_i),
    .is_hint_i   (is_hint_i),
    .is_sa_vld_i (is_sa_vld_i),
    .is_sa_i     (is_sa_i),
    .is_sb_vld_i (is_sb_vld_i),
    .wb_vld_i    (wb_vld_i),
    .wb_reg_i    (wb_reg_i),
    .is_susp_o   (is_susp_o),
    .is_retry_o  (is_retry_o),
    .q_cnt       (q_cnt)
);

// File: tb/dfs_sched_tb.sv
module dfs_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, iv, sav, sbv, asy, hint, wbv;
    logic [3:0]  itid;
    logic [15:0] ipc;
    logic [5:0]  sa, sb, dst, wbr;
    logic        fq_vld, susp, retry;
    logic [3:0]  fq_tid;
    logic [15:0] fq_pc;

    int n_chk = 0;
    int n_fail = 0;

    int   m_st [64];   // 0 FULL, 1 PENDING, 2 WAITING
    int   m_w  [64];
    int   m_pc [NT];
    bit   run  [NT];
    int   q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dfs_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .fq_req_i(req), .fq_vld_o(fq_vld), .fq_tid_o(fq_tid), .fq_pc_o(fq_pc),
        .is_vld_i(iv), .is_tid_i(itid), .is_pc_i(ipc),
        .is_sa_vld_i(sav), .is_sa_i(sa), .is_sb_vld_i(sbv), .is_sb_i(sb),
        .is_async_i(asy), .is_dst_i(dst), .is_hint_i(hint),
        .is_susp_o(susp), .is_retry_o(retry),
        .wb_vld_i(wbv), .wb_reg_i(wbr)
    );

    task automatic check(string req_s, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req_s, act, exp);
        end
    endtask

    task automatic idle();
        req = 0; iv = 0; sav = 0; sbv = 0; asy = 0; hint = 0; wbv = 0;
        itid = 0; ipc = 0; sa = 0; sb = 0; dst = 0; wbr = 0;
    endtask

    function automatic void issue(int t, int pc, bit va, int ra, bit vb, int rb,
                                  bit as, int d, bit h);
        iv = 1; itid = 4'(t); ipc = 16'(pc); sav = va; sa = 6'(ra); sbv = vb; sb = 6'(rb);
        asy = as; dst = 6'(d); hint = h;
    endfunction

    // one cycle: compare outputs with the model, then advance the model
    task automatic step();
        bit ba, bb, blk, es, er;
        int bst, breg;
        #1;
        ba   = sav && m_st[sa] != 0 && !(wbv && wbr == sa);
        bb   = sbv && m_st[sb] != 0 && !(wbv && wbr == sb);
        blk  = iv && (ba || bb);
        bst  = ba ? m_st[sa] : m_st[sb];
        breg = ba ? int'(sa) : int'(sb);
        es   = blk && bst == 1;
        er   = blk && bst == 2;
        check("R2 fetch valid", fq_vld, q.size() != 0);
        if (q.size() != 0) begin
            check("R2 R11 head thread", fq_tid, q[0]);
            check("R6 R9 R10 head pc", fq_pc, m_pc[q[0]]);
        end
        check("R3 R5 R8 suspend", susp, es);
        check("R10 retry", retry, er);
        if (req && q.size() != 0) begin
            run[q[0]] = 1;
            void'(q.pop_front());
        end
        if (wbv && m_st[wbr] == 2) q.push_back(m_w[wbr]);
        if (wbv) m_st[wbr] = 0;
        if (iv) begin
            if (es) begin
                m_st[breg] = 2; m_w[breg] = itid; m_pc[itid] = ipc; run[itid] = 0;
            end else if (er) begin
                q.push_back(itid); m_pc[itid] = ipc; run[itid] = 0;
            end else begin
                if (asy && m_st[dst] != 2) m_st[dst] = 1;
                if (hint) begin
                    q.push_back(itid); m_pc[itid] = 16'(ipc + 1); run[itid] = 0;
                end
            end
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        rst_n = 0;
        for (int r = 0; r < 64; r++) begin m_st[r] = 0; m_w[r] = 0; end
        for (int t = 0; t < NT; t++) begin m_pc[t] = 0; run[t] = 0; q.push_back(t); end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset order and PC
        check("R1 valid after reset", fq_vld, 1);
        for (int t = 0; t < NT; t++) begin
            check("R1 reset order", fq_tid, t);
            check("R1 reset pc", fq_pc, 0);
            req = 1; step();
        end
        check("R2 empty queue", fq_vld, 0);

        // R4: FULL sources never block
        issue(0, 5, 1, 1, 1, 2, 0, 0, 0);
        #1 check("R4 full sources", {susp, retry}, 0);
        step();

        // R3 R5: async marks pending, later read parks
        issue(0, 10, 0, 0, 0, 0, 1, 5, 0); step();
        issue(0, 11, 1, 5, 0, 0, 0, 0, 0);
        #1 check("R5 park on pending", susp, 1);
        step();
        check("R5 parked thread not queued", fq_vld, 0);

        // R10: second reader retries
        issue(1, 20, 0, 0, 1, 5, 0, 0, 0);
        #1 check("R10 waiter busy", retry, 1);
        step();
        check("R10 requeued thread", fq_tid, 1);
        check("R10 same pc", fq_pc, 20);
        req = 1; step();

        // R6: writeback wakes stored waiter
        wbv = 1; wbr = 5; step();
        check("R6 woken thread", fq_tid, 0);
        check("R6 restart pc", fq_pc, 11);
        req = 1; step();

        // R7: completion without waiter queues nothing
        issue(2, 30, 0, 0, 0, 0, 1, 6, 0); step();
        wbv = 1; wbr = 6; step();
        check("R7 no push", fq_vld, 0);

        // R8: same-cycle writeback and read
        issue(3, 35, 0, 0, 0, 0, 1, 7, 0); step();
        issue(3, 36, 1, 7, 0, 0, 0, 0, 0); wbv = 1; wbr = 7;
        #1 check("R8 bypass", susp, 0);
        step();

        // R9: hinted non-blocking instruction requeues with pc+1
        issue(4, 40, 1, 7, 0, 0, 0, 0, 1); step();
        check("R9 requeue thread", fq_tid, 4);
        check("R9 next pc", fq_pc, 41);
        req = 1; step();

        // R11: wake-up enters ahead of same-cycle requeue
        issue(5, 50, 0, 0, 0, 0, 1, 8, 0); step();
        issue(5, 51, 1, 8, 0, 0, 0, 0, 0); step();
        issue(6, 60, 0, 0, 0, 0, 0, 0, 1); wbv = 1; wbr = 8; step();
        check("R11 wake first", fq_tid, 5);
        check("R11 wake pc", fq_pc, 51);
        req = 1; step();
        check("R11 requeue second", fq_tid, 6);
        check("R11 requeue pc", fq_pc, 61);
        req = 1; step();

        // R12: park every thread, then wake all
        for (int t = 0; t < NT; t++) begin
            issue(t, 100 + t, 0, 0, 0, 0, 1, 16 + t, 0); step();
            issue(t, 200 + t, 1, 16 + t, 0, 0, 0, 0, 0); step();
        end
        for (int t = NT - 1; t >= 0; t--) begin wbv = 1; wbr = 6'(16 + t); step(); end
        for (int t = 0; t < NT; t++) begin
            check("R12 all woken", fq_tid, NT - 1 - t);
            check("R12 restart pc", fq_pc, 200 + NT - 1 - t);
            req = 1; step();
        end

        // constrained random phase over a small register window
        for (int c = 0; c < 3000; c++) begin
            int pick;
            req = ($urandom % 2) == 0;
            pick = -1;
            if (($urandom % 10) < 7) begin
                int s = $urandom % NT;
                for (int k = 0; k < NT; k++)
                    if (pick < 0 && run[(s + k) % NT]) pick = (s + k) % NT;
            end
            if (pick >= 0)
                issue(pick, $urandom % 65536, ($urandom % 4) != 0, $urandom % 8,
                      ($urandom % 2) == 0, $urandom % 8, ($urandom % 10) < 3,
                      $urandom % 8, ($urandom % 4) == 0);
            if (($urandom % 10) < 4) begin wbv = 1; wbr = 6'($urandom % 8); end
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule